// File: doc/BRIEF.md
# Four-Channel Shadow-Buffered PWM Generator

This block produces four pulse-width-modulated outputs from one shared 10-bit down-counter. Each channel has its own 10-bit compare value. Software writes the compare values and the counter reload value into shadow registers through a byte-wide register port. The working copies that shape the waveforms change only when the counter underflows, and only if a transfer has been requested while the block is running. This keeps every PWM period internally consistent, however slowly software writes a new set of values.

Each output goes high at underflow and falls when the counter meets that channel's compare value. Two compare encodings hold the output at a constant level. A per-channel invert bit flips the waveform. Clearing the run bit stops the counter and holds all outputs where they were. A pending transfer can be polled through the control register, and hardware clears it when the copy takes place.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After reset all shadow and working registers are 0, run and transfer are clear, every pwmOut bit is 0 and the counter is stopped.
- R2: Register map at regAddr. Addresses 0 to 3 hold compare bits 7:0 of channels 0 to 3. Address 4 holds compare bits 9:8 of channel n in bits 2n+1:2n. Address 5 holds reload bits 7:0 and address 6 holds reload bits 9:8 in bits 1:0. Address 7 is control: bit 0 run, bit 1 transfer, bits 5:2 invert for channels 0 to 3. rdData returns the stored value of the addressed register, with unused bits reading 0.
- R3: While running, the counter decrements by one each clock and reloads from the working reload value R on the cycle after it reads 0. That cycle is the underflow. A channel with working compare C, where 0 < C <= R and C != 0x3FF, is high for R-C+1 clocks of every R+1-clock period.
- R4: A working compare of 0 or a working compare greater than R holds the output permanently high.
- R5: A working compare of 0x3FF holds the output permanently low. This rule takes priority over R4.
- R6: Shadow values are copied to the working registers only at an underflow while transfer is set. The copy clears transfer, and rdData shows the cleared bit. Shadow writes made without a transfer do not change the waveform.
- R7: Setting transfer while run is clear copies nothing and transfer stays set. A later control write that sets run without transfer leaves the old working values in use.
- R8: A control write that sets run without transfer before the pending underflow cancels that transfer.
- R9: A set invert bit makes that channel's output the complement of its non-inverted waveform.
- R10: While run is clear the counter does not move and every pwmOut bit keeps the level it had when run was cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the addressed register |
| regAddr | input | 3 | Register address for writes and reads |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data of the addressed register |
| pwmOut | output | 4 | PWM outputs, channel n on bit n |

## Verification
A wrong counter or a wrong working compare value shows up at pwmOut as a wrong high time or a wrong period within one PWM period of the fault. The bench therefore measures whole periods edge to edge, after skipping one period so that it never catches a half-changed cycle. A transfer flag that is lost or stuck is visible on the next control read. It is also visible one period later as waveforms that kept their old shape, or changed when they should not have. Faults in the hold and freeze behaviour appear on the first clock after run clears.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int NUM_CH = 4;
  localparam int CMP_W  = 10;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;
  localparam int HI_W   = CMP_W - REG_W;

  // strobes from control to datapath
  typedef struct packed {
    logic              run;
    logic              load;
    logic              pend;
    logic [NUM_CH-1:0] inv;
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
  import pwm_shadow_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     wrData,
  input  logic                 atZero,
  output logic [REG_W-1:0]     rdData,
  output logic [CMP_W-1:0]     shCmp [NUM_CH],
  output logic [CMP_W-1:0]     shRld,
  output pwmStrobe_t           strobe
);
  localparam int A_HI  = NUM_CH;
  localparam int A_RLO = NUM_CH + 1;
  localparam int A_RHI = NUM_CH + 2;
  localparam int A_CTL = NUM_CH + 3;
  localparam int PAD_C = REG_W - 2 - NUM_CH;

  logic [REG_W-1:0]  cmpLo [NUM_CH];
  logic [REG_W-1:0]  cmpHi;
  logic [REG_W-1:0]  rldLo;
  logic [HI_W-1:0]   rldHi;
  logic              runQ, xferQ;
  logic [NUM_CH-1:0] invQ;
  logic              loadNow;

  assign loadNow = runQ && xferQ && atZero;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lo
    always_ff @(posedge clk) begin
      if (!rstN) cmpLo[ch] <= '0;
      else if (wrEn && regAddr == ADDR_W'(ch)) cmpLo[ch] <= wrData;
    end
    assign shCmp[ch] = {cmpHi[HI_W*ch +: HI_W], cmpLo[ch]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpHi <= '0;
      rldLo <= '0;
      rldHi <= '0;
      runQ  <= 1'b0;
      xferQ <= 1'b0;
      invQ  <= '0;
    end else begin
      if (wrEn && regAddr == ADDR_W'(A_HI))  cmpHi <= wrData;
      if (wrEn && regAddr == ADDR_W'(A_RLO)) rldLo <= wrData;
      if (wrEn && regAddr == ADDR_W'(A_RHI)) rldHi <= wrData[HI_W-1:0];
      if (wrEn && regAddr == ADDR_W'(A_CTL)) begin
        runQ  <= wrData[0];
        xferQ <= wrData[1];
        invQ  <= wrData[2 +: NUM_CH];
      end else if (loadNow) begin
        xferQ <= 1'b0;
      end
    end
  end

  assign shRld = {rldHi, rldLo};

  always_comb begin
    rdData = '0;
    for (int ch = 0; ch < NUM_CH; ch++)
      if (regAddr == ADDR_W'(ch)) rdData = cmpLo[ch];
    if (regAddr == ADDR_W'(A_HI))  rdData = cmpHi;
    if (regAddr == ADDR_W'(A_RLO)) rdData = rldLo;
    if (regAddr == ADDR_W'(A_RHI)) rdData = {{(REG_W-HI_W){1'b0}}, rldHi};
    if (regAddr == ADDR_W'(A_CTL)) rdData = {{PAD_C{1'b0}}, invQ, xferQ, runQ};
  end

  assign strobe.run  = runQ;
  assign strobe.load = loadNow;
  assign strobe.pend = xferQ;
  assign strobe.inv  = invQ;
endmodule

// File: rtl/pwm_shadow_dp.sv
module pwm_shadow_dp
  import pwm_shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrobe_t        strobe,
  input  logic [CMP_W-1:0]  shCmp [NUM_CH],
  input  logic [CMP_W-1:0]  shRld,
  output logic              atZero,
  output logic [CMP_W-1:0]  cntVal,
  output logic [CMP_W-1:0]  wrkRld,
  output logic [NUM_CH-1:0] pwmOut
);
  localparam logic [CMP_W-1:0] CMP_LOW = '1;

  logic [CMP_W-1:0]  cntQ, rldQ;
  logic [CMP_W-1:0]  cmpQ  [NUM_CH];
  logic [CMP_W-1:0]  cmpNx [NUM_CH];
  logic [CMP_W-1:0]  rldNx;
  logic [NUM_CH-1:0] rawQ, rawNx, outQ;
  logic              underflow;

  assign atZero    = (cntQ == '0);
  assign underflow = strobe.run && atZero;
  assign rldNx     = strobe.load ? shRld : rldQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign cmpNx[ch] = strobe.load ? shCmp[ch] : cmpQ[ch];

    always_comb begin
      rawNx[ch] = rawQ[ch];
      if (strobe.run) begin
        if (underflow)                rawNx[ch] = (cmpNx[ch] != CMP_LOW);
        else if (cntQ == cmpQ[ch])    rawNx[ch] = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpQ[ch] <= '0;
        rawQ[ch] <= 1'b0;
        outQ[ch] <= 1'b0;
      end else if (strobe.run) begin
        cmpQ[ch] <= cmpNx[ch];
        rawQ[ch] <= rawNx[ch];
        outQ[ch] <= rawNx[ch] ^ strobe.inv[ch];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      rldQ <= '0;
    end else if (strobe.run) begin
      rldQ <= rldNx;
      cntQ <= underflow ? rldNx : cntQ - 1'b1;
    end
  end

  assign cntVal = cntQ;
  assign wrkRld = rldQ;
  assign pwmOut = outQ;
endmodule

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen
  import pwm_shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  pwmStrobe_t       strobe;
  logic             atZero;
  logic [CMP_W-1:0] shCmp [NUM_CH];
  logic [CMP_W-1:0] shRld, cntVal, wrkRld;

  pwm_shadow_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .atZero(atZero), .rdData(rdData), .shCmp(shCmp), .shRld(shRld), .strobe(strobe)
  );

  pwm_shadow_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .shCmp(shCmp), .shRld(shRld),
    .atZero(atZero), .cntVal(cntVal), .wrkRld(wrkRld), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk
  import pwm_shadow_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              run,
  input logic              load,
  input logic              pend,
  input logic [CMP_W-1:0]  cnt,
  input logic [CMP_W-1:0]  wrkRld,
  input logic [NUM_CH-1:0] pwmOut
);
  logic ctlWr;
  assign ctlWr = wrEn && (regAddr == ADDR_W'(NUM_CH + 3));

  a_r10_outputs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> $stable(pwmOut));
  a_r10_counter_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> $stable(cnt));
  a_r6_transfer_self_clears: assert property (@(posedge clk) disable iff (!rstN)
    (load && !ctlWr) |=> !pend);
  a_r7_no_copy_while_idle: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> $stable(wrkRld));
  a_r3_reload_on_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (run && cnt == '0) |=> (cnt == wrkRld));
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rstN)
    (run && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

bind pwm_shadow_gen pwm_shadow_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
  .run(strobe.run), .load(strobe.load), .pend(strobe.pend),
  .cnt(cntVal), .wrkRld(wrkRld), .pwmOut(pwmOut)
);

// File: tb/pwm_shadow_gen_bench.sv
module pwm_shadow_gen_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [3:0] pwmOut;

  int nChk = 0;
  int nFail = 0;

  typedef struct {
    int    ch;
    bit    isConst;
    bit    lvl;
    int    expAct;
    int    expPer;
    string req;
  } item_t;
  item_t sbq[$];

  always #5 clk = ~clk;

  pwm_shadow_gen u_pwm_shadow_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = 3'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    regAddr = 3'(a);
    #1 d = int'(rdData);
  endtask

  task automatic push(input item_t it);
    sbq.push_back(it);
    wait (sbq.size() == 0);
  endtask

  task automatic waitXferDone();
    int d;
    for (int i = 0; i < 400; i++) begin
      rd(7, d);
      if (d[1] == 1'b0) break;
    end
  endtask

  // monitor: pops expected items and measures the waveform
  task automatic waitEdgeTo(input int ch, input bit lvl);
    bit prev;
    prev = pwmOut[ch];
    forever begin
      @(negedge clk);
      if (pwmOut[ch] == lvl && prev != lvl) break;
      prev = pwmOut[ch];
    end
  endtask

  initial begin
    forever begin
      item_t it;
      wait (sbq.size() > 0);
      it = sbq[0];
      if (it.isConst) begin
        int bad;
        bad = 0;
        for (int i = 0; i < 600; i++) begin
          @(negedge clk);
          if (pwmOut[it.ch] != it.lvl) bad++;
        end
        check($sformatf("%s ch%0d constant level, mismatching samples", it.req, it.ch), bad, 0);
      end else begin
        int act, per;
        waitEdgeTo(it.ch, it.lvl);
        waitEdgeTo(it.ch, it.lvl);
        act = 1;
        forever begin
          @(negedge clk);
          if (pwmOut[it.ch] == it.lvl) act++; else break;
        end
        per = act + 1;
        forever begin
          @(negedge clk);
          if (pwmOut[it.ch] != it.lvl) per++; else break;
        end
        check($sformatf("%s ch%0d active time", it.req, it.ch), act, it.expAct);
        check($sformatf("R3 ch%0d period", it.ch), per, it.expPer);
      end
      void'(sbq.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk + 1, nFail);
    $finish;
  end

  initial begin
    int d;
    logic [3:0] held;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    check("R1 pwmOut after reset", int'(pwmOut), 0);
    rd(7, d); check("R1 control after reset", d, 0);
    rd(0, d); check("R1 compare shadow after reset", d, 0);

    // R2 register layout: ch0=0x003 ch1=0x130 ch2=0x3FF ch3=0x100, reload=0x120
    wr(0, 8'h03); wr(1, 8'h30); wr(2, 8'hFF); wr(3, 8'h00);
    wr(4, 8'h74); wr(5, 8'h20); wr(6, 8'h01);
    rd(4, d); check("R2 packed high bits readback", d, 8'h74);
    rd(6, d); check("R2 reload high readback", d, 8'h01);
    rd(1, d); check("R2 compare ch1 low readback", d, 8'h30);
    repeat (20) @(negedge clk);
    check("R10 outputs idle before run", int'(pwmOut), 0);

    // R6 start with transfer
    wr(7, 8'h03);
    waitXferDone();
    rd(7, d); check("R6 transfer bit self-cleared", d, 8'h01);
    push('{0, 1'b0, 1'b1, 286, 289, "R3"});
    push('{3, 1'b0, 1'b1, 33, 289, "R2"});
    push('{1, 1'b1, 1'b1, 0, 0, "R4 above reload"});
    push('{2, 1'b1, 1'b0, 0, 0, "R5"});

    // R6 shadow write without transfer has no effect
    wr(0, 8'h50);
    push('{0, 1'b0, 1'b1, 286, 289, "R6 no transfer"});
    wr(1, 8'h00); wr(4, 8'h70); wr(7, 8'h03);
    waitXferDone();
    push('{0, 1'b0, 1'b1, 209, 289, "R6 after transfer"});
    push('{1, 1'b1, 1'b1, 0, 0, "R4 zero"});

    // R9 invert channel 3 (bit 5)
    wr(7, 8'h21);
    push('{3, 1'b0, 1'b0, 33, 289, "R9"});

    // R8 cancel pending transfer
    wr(0, 8'h10);
    wr(7, 8'h23);
    wr(7, 8'h21);
    repeat (300) @(negedge clk);
    rd(7, d); check("R8 transfer bit cancelled", d, 8'h21);
    push('{0, 1'b0, 1'b1, 209, 289, "R8"});

    // R10 freeze
    repeat (37) @(negedge clk);
    wr(7, 8'h20);
    held = pwmOut;
    repeat (100) @(negedge clk);
    check("R10 outputs held while stopped", int'(pwmOut), int'(held));

    // R7 transfer with run clear
    wr(7, 8'h22);
    repeat (400) @(negedge clk);
    rd(7, d); check("R7 transfer stays pending while stopped", d, 8'h22);
    check("R10 outputs still held", int'(pwmOut), int'(held));
    wr(7, 8'h21);
    push('{0, 1'b0, 1'b1, 209, 289, "R7"});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule